// File: doc/BRIEF.md
# Multichannel serial ADC scan controller

This block scans a 16-channel, 12-bit successive-approximation converter over a four-wire serial link: chip select, serial clock, command data to the converter and result data from the converter. The serial clock runs at half the system clock. Each serial clock phase takes one whole system clock, so the chip-select setup time and the converter's output delay fall inside one system clock period each, and no fast clock or delay counter is needed.

For every conversion frame the controller loads a 16-bit command word that carries the requested channel. It sends the word most significant bit first while it receives the 16-bit result. The received word holds a 4-bit channel tag above a 12-bit sample. The controller stores the sample in the one of sixteen holding registers that the tag selects, which is not always the channel it requested. It then raises a one-cycle strobe carrying the tag and the sample. The requested channel advances by one after each frame and wraps from 15 to 0. Scanning runs for as long as the enable input is high.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While chip select is high the serial clock is high. Within a frame the serial clock is low for exactly one system clock and then high for exactly one system clock, and it has exactly 16 low phases per frame.
- R2: Chip select falls while the serial clock is high, and stays low for exactly one system clock with the serial clock high before the first low phase.
- R3: The command word is {2'b10, channel[3:0], 10'b1100000000}, sent most significant bit first. Each bit is presented when the serial clock falls and holds unchanged through the following high phase.
- R4: The result line is sampled at the end of each low phase, which is the rising serial clock edge. The 16 samples form the received word, most significant bit first.
- R5: Bits [15:12] of the received word select the holding register and bits [11:0] are written into it. Register i appears on res_bank_o[12*i+11 : 12*i]. The other registers are unchanged.
- R6: After the 16th bit, chip select goes high and smp_valid_o is high for exactly one system clock. In that cycle smp_chan_o carries the received tag and smp_data_o carries the received sample. The holding register shows the new value from the next cycle on.
- R7: The requested channel starts at 0, increments after every frame and wraps from 15 to 0.
- R8: Between frames chip select stays high for at least one system clock.
- R9: While scan_en_i is low in idle, no frame starts. If scan_en_i drops during a frame, that frame completes and no further frame starts. The channel counter keeps its value, so scanning resumes with the next channel.
- R10: Reset (rst_ni low) puts the controller in idle with chip select high, serial clock high and smp_valid_o low. It clears all sixteen holding registers and sets the channel counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_en_i | input | 1 | Scanning enable |
| adc_miso_i | input | 1 | Serial result data from the converter |
| adc_cs_no | output | 1 | Converter chip select, active low |
| adc_sclk_o | output | 1 | Serial clock, half the system clock rate |
| adc_mosi_o | output | 1 | Serial command data to the converter |
| smp_valid_o | output | 1 | One-cycle strobe when a holding register is written |
| smp_chan_o | output | 4 | Channel tag of the stored sample |
| smp_data_o | output | 12 | Stored sample value |
| res_bank_o | output | 192 | Sixteen 12-bit holding registers, channel i at bits [12*i+11:12*i] |

## Verification
The assertions assume that the converter drives its result line only from falling serial clock edges and that scan_en_i is a synchronous level. Because of these assumptions they check only the link framing, the one-cycle strobe and the chip-select gap, and never the data values. The bench's converter model changes the result line only on the falling serial clock and records the command bit at each rising edge. The enable input changes only at the falling system clock edge. Random tags and samples, along with directed all-ones, all-zeros and mismatched-tag frames, stay within these assumptions.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int unsigned DEF_CH_W  = 4;
  localparam int unsigned DEF_SMP_W = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } scan_st_e;
endpackage

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_scan_pkg::*;
#(
  parameter int unsigned FRM_W = 16,
  parameter int unsigned CH_W  = 4,
  localparam int unsigned IDX_W = $clog2(FRM_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scan_en_i,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             load_o,
  output logic             cap_o,
  output logic             done_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic [CH_W-1:0]  chan_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRM_W - 1);

  scan_st_e         state_q, state_d;
  logic [IDX_W-1:0] bit_q;
  logic [CH_W-1:0]  chan_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (scan_en_i) state_d = ST_LOAD;
      ST_LOAD:  state_d = ST_SETUP;
      ST_SETUP: state_d = ST_LOW;
      ST_LOW:   state_d = ST_HIGH;
      ST_HIGH:  state_d = (bit_q == '0) ? ST_DONE : ST_LOW;
      ST_DONE:  state_d = scan_en_i ? ST_LOAD : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= LAST_IDX;
      chan_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_LOAD) bit_q <= LAST_IDX;
      else if (state_q == ST_HIGH && bit_q != '0) bit_q <= bit_q - 1'b1;  // falling sclk edge
      if (state_q == ST_DONE) chan_q <= chan_q + 1'b1;
    end
  end

  assign cs_no     = (state_q == ST_IDLE) || (state_q == ST_LOAD) || (state_q == ST_DONE);
  assign sclk_o    = (state_q != ST_LOW);
  assign load_o    = (state_q == ST_LOAD);
  assign cap_o     = (state_q == ST_LOW);  // capture on the edge that raises sclk
  assign done_o    = (state_q == ST_DONE);
  assign bit_idx_o = bit_q;
  assign chan_o    = chan_q;
endmodule

// File: rtl/adc_serdes.sv
module adc_serdes #(
  parameter int unsigned FRM_W = 16,
  parameter int unsigned CH_W  = 4,
  localparam int unsigned IDX_W  = $clog2(FRM_W),
  localparam int unsigned TAIL_W = FRM_W - 2 - CH_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             cap_i,
  input  logic             cs_ni,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic             miso_i,
  output logic             mosi_o,
  output logic [FRM_W-1:0] rx_word_o
);
  localparam logic [TAIL_W-1:0] TAIL = TAIL_W'(3) << (TAIL_W - 2);

  logic [FRM_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      tx_q <= {2'b10, chan_i, TAIL};
      rx_q <= '0;
    end else if (cap_i) begin
      rx_q <= {rx_q[FRM_W-2:0], miso_i};
    end
  end

  assign mosi_o    = cs_ni ? 1'b0 : tx_q[bit_idx_i];
  assign rx_word_o = rx_q;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int unsigned CH_W  = 4,
  parameter int unsigned SMP_W = 12,
  localparam int unsigned N_CH = 1 << CH_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [CH_W-1:0]       tag_i,
  input  logic [SMP_W-1:0]      data_i,
  output logic [N_CH*SMP_W-1:0] bank_o
);
  for (genvar i = 0; i < N_CH; i++) begin : g_slot
    logic [SMP_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q <= '0;
      else if (we_i && tag_i == CH_W'(i)) slot_q <= data_i;
    end
    assign bank_o[i*SMP_W +: SMP_W] = slot_q;
  end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int unsigned CH_W  = DEF_CH_W,
  parameter int unsigned SMP_W = DEF_SMP_W,
  localparam int unsigned FRM_W = CH_W + SMP_W,
  localparam int unsigned N_CH  = 1 << CH_W,
  localparam int unsigned IDX_W = $clog2(FRM_W)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scan_en_i,
  input  logic                  adc_miso_i,
  output logic                  adc_cs_no,
  output logic                  adc_sclk_o,
  output logic                  adc_mosi_o,
  output logic                  smp_valid_o,
  output logic [CH_W-1:0]       smp_chan_o,
  output logic [SMP_W-1:0]      smp_data_o,
  output logic [N_CH*SMP_W-1:0] res_bank_o
);
  logic             load, cap, done;
  logic [IDX_W-1:0] bit_idx;
  logic [CH_W-1:0]  chan;
  logic [FRM_W-1:0] rx_word;

  adc_frame_seq #(.FRM_W(FRM_W), .CH_W(CH_W)) i_seq (
    .clk_i, .rst_ni, .scan_en_i,
    .cs_no(adc_cs_no), .sclk_o(adc_sclk_o),
    .load_o(load), .cap_o(cap), .done_o(done),
    .bit_idx_o(bit_idx), .chan_o(chan)
  );

  adc_serdes #(.FRM_W(FRM_W), .CH_W(CH_W)) i_serdes (
    .clk_i, .rst_ni,
    .load_i(load), .cap_i(cap), .cs_ni(adc_cs_no),
    .bit_idx_i(bit_idx), .chan_i(chan),
    .miso_i(adc_miso_i), .mosi_o(adc_mosi_o), .rx_word_o(rx_word)
  );

  // route by the tag returned in the result, not by the requested channel
  assign smp_valid_o = done;
  assign smp_chan_o  = rx_word[FRM_W-1 -: CH_W];
  assign smp_data_o  = rx_word[SMP_W-1:0];

  adc_result_bank #(.CH_W(CH_W), .SMP_W(SMP_W)) i_bank (
    .clk_i, .rst_ni,
    .we_i(done), .tag_i(smp_chan_o), .data_i(smp_data_o),
    .bank_o(res_bank_o)
  );
endmodule

// File: rtl/adc_scan_checker.sv
module adc_scan_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic adc_cs_no,
  input logic adc_sclk_o,
  input logic adc_mosi_o,
  input logic smp_valid_o
);
  p_sclk_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_cs_no |-> adc_sclk_o);

  p_sclk_low_one_cycle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adc_cs_no && !adc_sclk_o) |=> adc_sclk_o);

  p_cs_setup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adc_cs_no && $past(adc_cs_no)) |-> adc_sclk_o);

  p_cs_setup_next_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adc_cs_no && $past(adc_cs_no)) |=> (!adc_cs_no && !adc_sclk_o));

  p_mosi_stable_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adc_cs_no && !adc_sclk_o) |=> $stable(adc_mosi_o));

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |=> !smp_valid_o);

  p_valid_cs_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> adc_cs_no);

  p_cs_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_cs_no) |=> adc_cs_no);
endmodule

bind adc_scan_ctrl adc_scan_checker i_adc_scan_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .adc_cs_no(adc_cs_no),
  .adc_sclk_o(adc_sclk_o), .adc_mosi_o(adc_mosi_o), .smp_valid_o(smp_valid_o)
);

// File: tb/test_adc_scan_ctrl.sv
module test_adc_scan_ctrl;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         scan_en_i = 1'b0;
  logic         adc_miso_i = 1'b0;
  logic         adc_cs_no, adc_sclk_o, adc_mosi_o, smp_valid_o;
  logic [3:0]   smp_chan_o;
  logic [11:0]  smp_data_o;
  logic [191:0] res_bank_o;

  adc_scan_ctrl i_adc_scan_ctrl (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] next_rsp, cur_rsp, got_cmd;
  logic [11:0] exp_bank [16];
  logic [3:0]  exp_req = 4'd0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] cmd_word(input logic [3:0] ch);
    return {2'b10, ch, 10'b1100000000};
  endfunction

  // converter model: new bit after each falling sclk, records command at rising sclk
  initial begin
    forever begin
      @(negedge adc_cs_no);
      cur_rsp = next_rsp;
      for (int k = 15; k >= 0; k--) begin
        @(negedge adc_sclk_o);
        adc_miso_i = cur_rsp[k];
        @(posedge adc_sclk_o);
        got_cmd[k] = adc_mosi_o;
      end
    end
  end

  // link framing monitor
  int  hi_run = 0, lo_run = 0, low_phases = 0;
  bit  prev_cs = 1, first_low = 0, seen_frame = 0, prev_sclk = 1;
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (adc_cs_no && !adc_sclk_o) chk(0, "R1", "sclk low while cs high", 0, 1);
      if (!adc_cs_no && prev_cs) begin
        chk(adc_sclk_o == 1'b1, "R2", "sclk at cs fall", adc_sclk_o, 1);
        if (seen_frame) chk(hi_run >= 1, "R8", "cs high gap", hi_run, 1);
        lo_run = 0; low_phases = 0; first_low = 1; seen_frame = 1;
      end
      if (!adc_cs_no) begin
        lo_run++;
        if (!adc_sclk_o) begin
          if (!prev_sclk) chk(0, "R1", "sclk low two cycles", 0, 1);
          low_phases++;
          if (first_low) chk(lo_run == 2, "R2", "cs-to-sclk setup cycles", lo_run - 1, 1);
          first_low = 0;
        end
        hi_run = 0;
      end else begin
        if (!prev_cs) chk(low_phases == 16, "R1", "sclk low phases per frame", low_phases, 16);
        hi_run++;
      end
      prev_cs = adc_cs_no;
      prev_sclk = adc_sclk_o;
    end else begin
      prev_cs = 1; prev_sclk = 1; hi_run = 0;
    end
  end

  task automatic wait_valid(output bit ok);
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (smp_valid_o) begin ok = 1; break; end
    end
  endtask

  task automatic check_bank(input string req);
    for (int c = 0; c < 16; c++)
      chk(res_bank_o[12*c +: 12] == exp_bank[c], req, $sformatf("bank slot %0d", c),
          res_bank_o[12*c +: 12], exp_bank[c]);
  endtask

  // one frame: response already in next_rsp
  task automatic run_frame(input logic [15:0] nxt);
    bit ok;
    logic [15:0] rsp;
    rsp = next_rsp;
    wait_valid(ok);
    chk(ok, "R6", "valid strobe seen", ok, 1);
    next_rsp = nxt;
    if (ok) begin
      chk(smp_chan_o == rsp[15:12], "R6", "strobe tag", smp_chan_o, rsp[15:12]);
      chk(smp_data_o == rsp[11:0], "R4", "strobe sample", smp_data_o, rsp[11:0]);
      chk(adc_cs_no == 1'b1, "R6", "cs high at strobe", adc_cs_no, 1);
      chk(got_cmd == cmd_word(exp_req), "R3", "command word", got_cmd, cmd_word(exp_req));
      chk(got_cmd[13:10] == exp_req, "R7", "requested channel", got_cmd[13:10], exp_req);
      exp_bank[rsp[15:12]] = rsp[11:0];
      exp_req = exp_req + 4'd1;
      @(negedge clk_i);
      chk(smp_valid_o == 1'b0, "R6", "strobe one cycle", smp_valid_o, 0);
      chk(res_bank_o[12*rsp[15:12] +: 12] == rsp[11:0], "R5", "routed slot",
          res_bank_o[12*rsp[15:12] +: 12], rsp[11:0]);
    end
  endtask

  function automatic logic [15:0] rnd_rsp();
    return 16'($urandom);
  endfunction

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    chk(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    bit ok;
    void'($urandom(32'h5eed_0042));
    for (int c = 0; c < 16; c++) exp_bank[c] = '0;
    next_rsp = 16'hFFFF;

    repeat (3) @(negedge clk_i);
    chk(adc_cs_no == 1, "R10", "cs in reset", adc_cs_no, 1);
    chk(adc_sclk_o == 1, "R10", "sclk in reset", adc_sclk_o, 1);
    chk(smp_valid_o == 0, "R10", "valid in reset", smp_valid_o, 0);
    chk(res_bank_o == '0, "R10", "bank cleared", 0, 0);
    rst_ni = 1'b1;

    repeat (5) @(negedge clk_i);
    chk(adc_cs_no == 1, "R9", "idle without enable", adc_cs_no, 1);

    scan_en_i = 1'b1;
    // directed: full scale on tag 15, zero on tag 0, then tag differs from request
    run_frame(16'h0000);
    run_frame(16'h5A5C);
    run_frame(rnd_rsp());
    for (int f = 0; f < 18; f++) run_frame(rnd_rsp());
    check_bank("R5");

    // drop enable in the middle of a frame
    @(negedge clk_i);
    while (adc_cs_no) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    scan_en_i = 1'b0;
    run_frame(rnd_rsp());
    ok = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      if (!adc_cs_no || smp_valid_o) ok = 0;
    end
    chk(ok, "R9", "no frame after enable drop", ok, 1);

    scan_en_i = 1'b1;
    for (int f = 0; f < 4; f++) run_frame(rnd_rsp());
    check_bank("R5");

    scan_en_i = 1'b0;
    run_frame(rnd_rsp());
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(res_bank_o == '0, "R10", "bank cleared by reset", 0, 0);
    chk(adc_cs_no == 1, "R10", "cs after reset", adc_cs_no, 1);
    for (int c = 0; c < 16; c++) exp_bank[c] = '0;
    exp_req = 4'd0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    scan_en_i = 1'b1;
    run_frame(rnd_rsp());
    scan_en_i = 1'b0;
    check_bank("R10");
    repeat (10) @(negedge clk_i);
    finish_run();
  end
endmodule